// File: doc/BRIEF.md
# Disk sector read sequencer

The block follows the angular position of a rotating disk from two pulse streams. An index pulse says that the next sector pulse opens sector 0. Each later sector pulse opens the next sector, and the count wraps after the last sector of the track. Software-side logic arms the sequencer with a start strobe and a target sector number. The sequencer then waits until the target sector comes under the head and signals the hit with a one-cycle pulse.

After the hit, three record reads run in a fixed order: a 2-word header, an 8-word label and a 256-word data record. For each record the sequencer hands a start pulse and a word count to a separate field reader. It waits for that reader's done strobe and samples its checksum verdict at the same time. When the data record finishes, a status word shows completion and any checksum failure per record.

All of this must end before the next sector pulse. A sector pulse that arrives while a record chain is still running aborts the chain and is reported as an overrun.

Top module: `disk_sector_seq`

States of the controller:
- `ST_IDLE`: not busy. The start strobe moves it to `ST_ARMED`.
- `ST_ARMED`: waits for a sector pulse whose derived number equals the target. A hit moves it to `ST_MATCH`.
- `ST_MATCH`: one cycle with the hit pulse high. Then it moves to `ST_LAUNCH`.
- `ST_LAUNCH`: one cycle with the field start high. Then it moves to `ST_WAIT`.
- `ST_WAIT`: waits for the reader's done strobe. On done it goes back to `ST_LAUNCH` for the next record, or to `ST_IDLE` after the data record.
- Overrun transition: a sector pulse in `ST_MATCH`, `ST_LAUNCH` or `ST_WAIT` goes straight to `ST_IDLE`.

## Requirements
- R1: After reset, busy, got-sector, field start and all status bits are 0.
- R2: After an index pulse, the next sector pulse is sector 0. Each later pulse adds one, and after sector SECTORS_PER_TRACK-1 (default 12 sectors) the count wraps to 0 with no index pulse needed.
- R3: If no index pulse has been seen since reset, no sector pulse can produce a hit, and the sequencer stays busy and armed.
- R4: An index pulse arriving in the middle of a track makes the next sector pulse sector 0, whatever the count was.
- R5: A start strobe while not busy latches the target, clears the status word to 0 and sets busy in the next cycle. The got-sector output is a single-cycle pulse, raised in the cycle after the sector pulse that matches the target.
- R6: The header field start is a one-cycle pulse in the cycle after got-sector, with length 2. The label start (length 8) and the data start (length 256) each come in the cycle after the previous record's done strobe. No field start occurs while a record is still being read.
- R7: Status bits 1, 2 and 3 hold the inverse of the checksum-ok input, sampled with the done strobe of the header, label and data record respectively.
- R8: In the cycle after the data record's done strobe, busy is 0 and status bit 0 (done) is 1.
- R9: A sector pulse while the record chain runs sets status bit 4 (overrun) and bit 0, clears busy in the next cycle and starts no further record.
- R10: A start strobe while busy is ignored: the status is not cleared and the target and record chain continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Arm strobe, one cycle |
| target_i | input | 4 | Sector number to read |
| index_mark_i | input | 1 | Index pulse, one cycle |
| sector_mark_i | input | 1 | Sector pulse, one cycle |
| fld_done_i | input | 1 | Field reader finished the current record |
| fld_crc_ok_i | input | 1 | Checksum verdict, valid with fld_done_i |
| got_sector_o | output | 1 | Target sector reached, one cycle |
| fld_start_o | output | 1 | Start a record read, one cycle |
| fld_len_o | output | 9 | Word count of the record being started |
| busy_o | output | 1 | Sequencer armed or reading |
| status_o | output | 5 | {overrun, data fail, label fail, header fail, done} |

## Verification
The hardest situations to reach are the ones where the sector count must come from something other than a fresh index pulse. One is the wrap from the last sector to sector 0. The other is an index pulse landing mid-track. To reach the wrap, the bench runs a whole revolution of sector pulses before arming, so the first candidate pulse after the start is a wrapped sector 0. The overrun and the ignored-start cases need a stimulus timed into the middle of the label wait. The bench holds back the reader's done strobe so that a sector pulse or a second start strobe lands there.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_MATCH,
        ST_LAUNCH,
        ST_WAIT
    } dss_state_e;

    localparam int STATUS_W = 5;
    localparam int ST_DONE  = 0;
    localparam int ST_HFAIL = 1;
    localparam int ST_LFAIL = 2;
    localparam int ST_DFAIL = 3;
    localparam int ST_OVR   = 4;

endpackage

// File: rtl/dss_sector_track.sv
module dss_sector_track #(
    parameter int SECTORS_PER_TRACK = 12,
    parameter int SEC_W = $clog2(SECTORS_PER_TRACK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             index_i,
    input  logic             mark_i,
    output logic             mark_valid_o,
    output logic [SEC_W-1:0] mark_num_o
);
    localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(SECTORS_PER_TRACK - 1);

    logic             pending_q;
    logic             valid_q;
    logic [SEC_W-1:0] cnt_q;
    logic [SEC_W-1:0] cnt_nxt;

    always_comb begin
        if (pending_q)
            cnt_nxt = '0;
        else if (cnt_q == LAST_SEC)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt_q + 1'b1;
    end

    assign mark_valid_o = pending_q | valid_q;
    assign mark_num_o   = cnt_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            valid_q   <= 1'b0;
            cnt_q     <= '0;
        end else begin
            if (mark_i) begin
                if (pending_q || valid_q) begin
                    cnt_q   <= cnt_nxt;
                    valid_q <= 1'b1;
                end
                pending_q <= 1'b0;
            end
            if (index_i)
                pending_q <= 1'b1;
        end
    end

    // R2: count stays inside the track
    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_SEC);

    // R4: first mark after an index always lands on sector 0
    a_r4_index_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && mark_i && !index_i) |=> (cnt_q == '0 && valid_q));

endmodule

// File: rtl/dss_read_fsm.sv
module dss_read_fsm
    import dss_pkg::*;
#(
    parameter int SEC_W     = 4,
    parameter int HDR_WORDS = 2,
    parameter int LBL_WORDS = 8,
    parameter int DAT_WORDS = 256,
    parameter int LEN_W     = $clog2(DAT_WORDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SEC_W-1:0]    target_i,
    input  logic                mark_i,
    input  logic                mark_valid_i,
    input  logic [SEC_W-1:0]    mark_num_i,
    input  logic                fld_done_i,
    input  logic                fld_crc_ok_i,
    output logic                got_sector_o,
    output logic                fld_start_o,
    output logic [LEN_W-1:0]    fld_len_o,
    output logic                busy_o,
    output logic [STATUS_W-1:0] status_o
);
    localparam logic [1:0] REC_HDR = 2'd0;
    localparam logic [1:0] REC_LBL = 2'd1;
    localparam logic [1:0] REC_DAT = 2'd2;

    dss_state_e          state_q, state_d;
    logic [SEC_W-1:0]    target_q;
    logic [1:0]          rec_q;
    logic [STATUS_W-1:0] status_q;
    logic                hit;
    logic                in_chain;

    assign hit      = mark_i && mark_valid_i && (mark_num_i == target_q);
    assign in_chain = (state_q == ST_MATCH) || (state_q == ST_LAUNCH) ||
                      (state_q == ST_WAIT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ARMED;
            ST_ARMED:  if (hit) state_d = ST_MATCH;
            ST_MATCH:  state_d = mark_i ? ST_IDLE : ST_LAUNCH;
            ST_LAUNCH: state_d = mark_i ? ST_IDLE : ST_WAIT;
            ST_WAIT: begin
                if (mark_i)
                    state_d = ST_IDLE;
                else if (fld_done_i)
                    state_d = (rec_q == REC_DAT) ? ST_IDLE : ST_LAUNCH;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
            rec_q    <= REC_HDR;
            status_q <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            target_q <= target_i;
            rec_q    <= REC_HDR;
            status_q <= '0;
        end else if (in_chain && mark_i) begin
            status_q[ST_OVR]  <= 1'b1;
            status_q[ST_DONE] <= 1'b1;
        end else if (state_q == ST_WAIT && fld_done_i) begin
            unique case (rec_q)
                REC_HDR: status_q[ST_HFAIL] <= !fld_crc_ok_i;
                REC_LBL: status_q[ST_LFAIL] <= !fld_crc_ok_i;
                default: status_q[ST_DFAIL] <= !fld_crc_ok_i;
            endcase
            if (rec_q == REC_DAT)
                status_q[ST_DONE] <= 1'b1;
            else
                rec_q <= rec_q + 2'd1;
        end
    end

    always_comb begin
        got_sector_o = (state_q == ST_MATCH);
        fld_start_o  = (state_q == ST_LAUNCH);
        busy_o       = (state_q != ST_IDLE);
        status_o     = status_q;
        unique case (rec_q)
            REC_HDR: fld_len_o = LEN_W'(HDR_WORDS);
            REC_LBL: fld_len_o = LEN_W'(LBL_WORDS);
            default: fld_len_o = LEN_W'(DAT_WORDS);
        endcase
    end

    // R5: a hit only follows a sector mark
    a_r5_got_after_mark: assert property (@(posedge clk) disable iff (!rst_n)
        got_sector_o |-> $past(mark_i));

    // R5: arming clears status and raises busy
    a_r5_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && status_o == '0));

    // R6: header start directly follows the hit
    a_r6_hdr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (got_sector_o && !mark_i) |=> (fld_start_o && fld_len_o == LEN_W'(HDR_WORDS)));

    // R6: field start is a single-cycle pulse
    a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fld_start_o |=> !fld_start_o);

    // R8: leaving busy always reports done
    a_r8_done_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> status_o[ST_DONE]);

    // R9: a mark during the chain aborts with overrun
    a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (in_chain && mark_i) |=> (!busy_o && status_o[ST_OVR]));

    // R10: start while reading keeps status
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && start_i && !mark_i && !fld_done_i) |=> $stable(status_o));

endmodule

// File: rtl/disk_sector_seq.sv
module disk_sector_seq
    import dss_pkg::*;
#(
    parameter int SECTORS_PER_TRACK = 12,
    parameter int HDR_WORDS         = 2,
    parameter int LBL_WORDS         = 8,
    parameter int DAT_WORDS         = 256,
    localparam int SEC_W            = $clog2(SECTORS_PER_TRACK),
    localparam int LEN_W            = $clog2(DAT_WORDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SEC_W-1:0]    target_i,
    input  logic                index_mark_i,
    input  logic                sector_mark_i,
    input  logic                fld_done_i,
    input  logic                fld_crc_ok_i,
    output logic                got_sector_o,
    output logic                fld_start_o,
    output logic [LEN_W-1:0]    fld_len_o,
    output logic                busy_o,
    output logic [STATUS_W-1:0] status_o
);
    logic             mark_valid;
    logic [SEC_W-1:0] mark_num;

    dss_sector_track #(
        .SECTORS_PER_TRACK (SECTORS_PER_TRACK),
        .SEC_W             (SEC_W)
    ) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .index_i      (index_mark_i),
        .mark_i       (sector_mark_i),
        .mark_valid_o (mark_valid),
        .mark_num_o   (mark_num)
    );

    dss_read_fsm #(
        .SEC_W     (SEC_W),
        .HDR_WORDS (HDR_WORDS),
        .LBL_WORDS (LBL_WORDS),
        .DAT_WORDS (DAT_WORDS),
        .LEN_W     (LEN_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .target_i     (target_i),
        .mark_i       (sector_mark_i),
        .mark_valid_i (mark_valid),
        .mark_num_i   (mark_num),
        .fld_done_i   (fld_done_i),
        .fld_crc_ok_i (fld_crc_ok_i),
        .got_sector_o (got_sector_o),
        .fld_start_o  (fld_start_o),
        .fld_len_o    (fld_len_o),
        .busy_o       (busy_o),
        .status_o     (status_o)
    );

endmodule

// File: tb/tb_disk_sector_seq.sv
module tb_disk_sector_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SPT        = 12;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] target_i = '0;
    logic       index_mark_i = 1'b0;
    logic       sector_mark_i = 1'b0;
    logic       fld_done_i = 1'b0;
    logic       fld_crc_ok_i = 1'b0;
    logic       got_sector_o;
    logic       fld_start_o;
    logic [8:0] fld_len_o;
    logic       busy_o;
    logic [4:0] status_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    disk_sector_seq dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .target_i (target_i),
        .index_mark_i (index_mark_i), .sector_mark_i (sector_mark_i),
        .fld_done_i (fld_done_i), .fld_crc_ok_i (fld_crc_ok_i),
        .got_sector_o (got_sector_o), .fld_start_o (fld_start_o),
        .fld_len_o (fld_len_o), .busy_o (busy_o), .status_o (status_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_index();
        @(negedge clk) index_mark_i = 1'b1;
        @(negedge clk) index_mark_i = 1'b0;
    endtask

    task automatic pulse_mark(input bit exp_got, input string req);
        @(negedge clk) sector_mark_i = 1'b1;
        @(negedge clk) sector_mark_i = 1'b0;
        check(got_sector_o == exp_got, req, int'(got_sector_o), int'(exp_got));
    endtask

    task automatic pulse_start(input int tgt);
        @(negedge clk) begin start_i = 1'b1; target_i = 4'(tgt); end
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic pulse_done(input bit ok);
        @(negedge clk) begin fld_done_i = 1'b1; fld_crc_ok_i = ok; end
        @(negedge clk) begin fld_done_i = 1'b0; fld_crc_ok_i = 1'b0; end
    endtask

    function automatic int rec_len(input int i);
        return (i == 0) ? 2 : (i == 1) ? 8 : 256;
    endfunction

    // Called right after a hit was sampled; mask bit i = record i fails
    task automatic run_records(input int mask);
        @(negedge clk);
        check(fld_start_o && fld_len_o == 9'(rec_len(0)), "R6 header launch",
              int'(fld_len_o), rec_len(0));
        for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 2; j++) begin
                @(negedge clk);
                check(!fld_start_o && busy_o, "R6 no launch while reading",
                      int'(fld_start_o), 0);
            end
            pulse_done(!mask[i]);
            if (i < 2)
                check(fld_start_o && fld_len_o == 9'(rec_len(i+1)), "R6 next launch",
                      int'(fld_len_o), rec_len(i+1));
            else begin
                check(!busy_o && status_o[0], "R8 done and idle",
                      int'({busy_o, status_o[0]}), 1);
                check(status_o[3:1] == 3'(mask), "R7 checksum bits",
                      int'(status_o[3:1]), mask & 7);
            end
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check(!busy_o && !got_sector_o && !fld_start_o && status_o == '0,
              "R1 reset state", int'({busy_o, got_sector_o, fld_start_o, status_o}), 0);

        // R3 no index seen: no hit
        pulse_start(0);
        check(busy_o && status_o == '0, "R5 arm", int'(status_o), 0);
        for (int k = 0; k < SPT + 2; k++) pulse_mark(1'b0, "R3 no hit without index");
        check(busy_o, "R3 stays armed", int'(busy_o), 1);

        // R2/R5/R6/R7/R8 sweep over every target
        do_reset();
        for (int t = 0; t < SPT; t++) begin
            pulse_index();
            pulse_start(t);
            check(busy_o && status_o == '0, "R5 arm clears", int'(status_o), 0);
            for (int k = 0; k <= t; k++) pulse_mark(k == t, "R2 R5 sector numbering");
            run_records(t % 8);
        end

        // R7 every checksum pattern
        for (int m = 0; m < 8; m++) begin
            pulse_index();
            pulse_start(1);
            pulse_mark(1'b0, "R2 sector 0");
            pulse_mark(1'b1, "R5 hit sector 1");
            run_records(m);
        end

        // R2 wrap: full revolution then sector 0 again
        pulse_index();
        for (int k = 0; k < SPT; k++) pulse_mark(1'b0, "R2 idle revolution");
        pulse_start(1);
        pulse_mark(1'b0, "R2 wrapped to 0");
        pulse_mark(1'b1, "R2 wrapped then 1");
        run_records(0);

        // R4 mid-track index
        pulse_index();
        for (int k = 0; k < 3; k++) pulse_mark(1'b0, "R4 pre marks");
        pulse_start(0);
        pulse_index();
        pulse_mark(1'b1, "R4 index restarts count");
        run_records(0);

        // R9 overrun during label read
        pulse_index();
        pulse_start(2);
        for (int k = 0; k <= 2; k++) pulse_mark(k == 2, "R5 hit sector 2");
        @(negedge clk);
        check(fld_start_o, "R6 header launch", int'(fld_start_o), 1);
        pulse_done(1'b0);
        check(fld_start_o && fld_len_o == 9'd8, "R6 label launch", int'(fld_len_o), 8);
        @(negedge clk);
        pulse_mark(1'b0, "R9 mark in chain");
        check(!busy_o && status_o == 5'b10011, "R9 overrun status",
              int'(status_o), 5'b10011);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!fld_start_o, "R9 no further record", int'(fld_start_o), 0);
        end

        // R10 start while busy ignored
        pulse_index();
        pulse_start(0);
        pulse_mark(1'b1, "R5 hit sector 0");
        @(negedge clk);
        pulse_done(1'b0);
        check(fld_start_o && fld_len_o == 9'd8, "R6 label launch", int'(fld_len_o), 8);
        @(negedge clk);
        pulse_start(5);
        check(busy_o && status_o == 5'b00010, "R10 start ignored",
              int'(status_o), 5'b00010);
        pulse_done(1'b1);
        check(fld_start_o && fld_len_o == 9'd256, "R10 chain continues",
              int'(fld_len_o), 256);
        @(negedge clk);
        pulse_done(1'b1);
        check(!busy_o && status_o == 5'b00011, "R10 R8 final status",
              int'(status_o), 5'b00011);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule